// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Sequencer

This block loads a downstream FPGA over its slave-serial configuration pins. On a start request it pulls the active-low program line low and waits for the target to acknowledge by dropping its init line. It then releases program and waits for init to rise again. After that it takes configuration bytes from an upstream source and shifts them out one bit at a time, most significant bit first, under a configuration clock that it generates itself. Finally it waits for the target's done line and reports either success or which of the three wait phases ran out of time.

Each of the three waits has the same time limit: a fixed number of poll intervals, each a set number of system clocks. The target's init and done lines pass through two-flop synchronisers before the block uses them. Each configuration clock phase lasts a set number of system clocks. Because of this the pin timing can be slowed to suit the target. An optional padding mode appends a run of all-ones bytes after the last source byte.

Top module: `fpga_serial_loader`

## Requirements
- R1: After reset the program, configuration clock and data pins are high, and busy, done and the error code (2 bits, 0 = none) are all zero.
- R2: A start request while idle raises busy and drives program low while the configuration clock and data stay high.
- R3: If the synchronised init line does not go low within POLL_CLKS*POLL_LIMIT cycles of program going low, the block goes idle with error code 1 and program released high.
- R4: After init goes low, program is released. If init does not return high within the same limit, the block goes idle with error code 2.
- R5: Each bit has four phases of PHASE_CLKS cycles each. In order they are: clock low; clock low with the bit on the data pin; clock high with the bit held; clock high. The data pin never changes at a rising clock edge, and rising edges inside a byte are 4*PHASE_CLKS cycles apart.
- R6: The data pin is high at every falling edge of the configuration clock, so it returns high after each zero bit.
- R7: Each source byte is sent most significant bit first. Bytes go out in the order they were accepted.
- R8: When pad_ones was high at start, PAD_BYTES bytes of all ones (PAD_BYTES*8 one bits) follow the byte marked last. When it was low, nothing follows.
- R9: If the synchronised done line does not go high within the limit after the last bit, the block goes idle with error code 3.
- R10: On success the block goes idle with done high and error code 0. The result holds until the next start.
- R11: src_ready is high only while the block is waiting for a byte, and exactly one byte is taken per cycle with src_valid and src_ready both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| pad_ones | input | 1 | Append all-ones padding after the last byte; sampled at start |
| src_valid | input | 1 | Source byte available |
| src_data | input | BYTE_W | Source byte |
| src_last | input | 1 | Marks the final source byte |
| src_ready | output | 1 | Block accepts a byte this cycle |
| cfg_prog_n | output | 1 | Active-low program pin to the target |
| cfg_cclk | output | 1 | Generated configuration clock |
| cfg_din | output | 1 | Serial configuration data |
| cfg_init_n | input | 1 | Target init line (low while clearing) |
| cfg_done | input | 1 | Target done line |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run succeeded |
| err_code | output | 2 | 0 none, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
The bench sweeps stream lengths of one to four bytes, with and without padding, using bytes of all zeros, all ones, a lone top bit, a lone bottom bit and mixed values. It rebuilds the expected bit train arithmetically. A design that sent bits least significant first, skipped or doubled the padding, or took extra bytes would show a mismatch in order or bit count. It also checks that no zero is left on the data pin at a falling clock edge and that the bit period stays fixed. Each of the three waits is made to fail in turn. The bench checks the error code and, for the two init waits, that the error appears at the expected cycle count. A swapped code or a limit off by a poll interval would be caught this way.

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader #(
  parameter int BYTE_W     = 8,
  parameter int PHASE_CLKS = 4,
  parameter int POLL_CLKS  = 25000,
  parameter int POLL_LIMIT = 4,
  parameter int PAD_BYTES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pad_ones,
  input  logic              src_valid,
  input  logic [BYTE_W-1:0] src_data,
  input  logic              src_last,
  output logic              src_ready,
  output logic              cfg_prog_n,
  output logic              cfg_cclk,
  output logic              cfg_din,
  input  logic              cfg_init_n,
  input  logic              cfg_done,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code
);
  localparam int TMO = POLL_CLKS * POLL_LIMIT;
  localparam int TW  = $clog2(TMO + 1);
  localparam int PCW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam int BIW = $clog2(BYTE_W);
  localparam int PDW = $clog2(PAD_BYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_WINIT, S_FETCH, S_SHIFT, S_WDONE} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [PCW-1:0]   ph_cnt;
  logic [1:0]       ph;
  logic [BIW-1:0]   bit_idx;
  logic [BYTE_W-1:0] shreg;
  logic             last_q;
  logic [PDW-1:0]   pad_left;
  logic             done_q;
  logic [1:0]       err_q;
  logic             init_m, init_s, done_m, done_s;
  logic             prog_n_q, cclk_q, din_q;

  wire tmo_hit  = (tmr == TW'(TMO - 1));
  wire ph_end   = (ph_cnt == PCW'(PHASE_CLKS - 1));
  wire byte_end = (bit_idx == BIW'(BYTE_W - 1));

  assign src_ready  = (st == S_FETCH);
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign err_code   = err_q;
  assign cfg_prog_n = prog_n_q;
  assign cfg_cclk   = cclk_q;
  assign cfg_din    = din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_m <= 1'b1; init_s <= 1'b1;
      done_m <= 1'b0; done_s <= 1'b0;
    end else begin
      init_m <= cfg_init_n; init_s <= init_m;
      done_m <= cfg_done;   done_s <= done_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_n_q <= 1'b1;
      cclk_q   <= 1'b1;
      din_q    <= 1'b1;
    end else begin
      prog_n_q <= (st != S_PROG);
      cclk_q   <= !(st == S_SHIFT && !ph[1]);
      din_q    <= !(st == S_SHIFT && (ph == 2'd1 || ph == 2'd2) && !shreg[BYTE_W-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      ph_cnt   <= '0;
      ph       <= 2'd0;
      bit_idx  <= '0;
      shreg    <= '1;
      last_q   <= 1'b0;
      pad_left <= '0;
      done_q   <= 1'b0;
      err_q    <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_PROG;
          tmr      <= '0;
          done_q   <= 1'b0;
          err_q    <= 2'd0;
          pad_left <= pad_ones ? PDW'(PAD_BYTES) : '0;
        end
        S_PROG: begin
          if (!init_s) begin
            st  <= S_WINIT;
            tmr <= '0;
          end else if (tmo_hit) begin
            st    <= S_IDLE;
            err_q <= 2'd1;
          end else tmr <= tmr + 1'b1;
        end
        S_WINIT: begin
          if (init_s) st <= S_FETCH;
          else if (tmo_hit) begin
            st    <= S_IDLE;
            err_q <= 2'd2;
          end else tmr <= tmr + 1'b1;
        end
        S_FETCH: if (src_valid) begin
          st      <= S_SHIFT;
          shreg   <= src_data;
          last_q  <= src_last;
          ph      <= 2'd0;
          ph_cnt  <= '0;
          bit_idx <= '0;
        end
        S_SHIFT: begin
          if (!ph_end) ph_cnt <= ph_cnt + 1'b1;
          else begin
            ph_cnt <= '0;
            ph     <= ph + 2'd1;
            if (ph == 2'd3) begin
              if (!byte_end) begin
                bit_idx <= bit_idx + 1'b1;
                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
              end else begin
                bit_idx <= '0;
                if (!last_q) st <= S_FETCH;
                else if (pad_left != '0) begin
                  shreg    <= '1;
                  pad_left <= pad_left - 1'b1;
                end else begin
                  st  <= S_WDONE;
                  tmr <= '0;
                end
              end
            end
          end
        end
        S_WDONE: begin
          if (done_s) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else if (tmo_hit) begin
            st    <= S_IDLE;
            err_q <= 2'd3;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module fpga_serial_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       src_ready,
  input logic       cfg_prog_n,
  input logic       cfg_cclk,
  input logic       cfg_din,
  input logic       busy,
  input logic       done,
  input logic [1:0] err_code
);
  assert_prog_lines_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> (cfg_cclk && cfg_din));
  assert_din_stable_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_cclk) |-> $stable(cfg_din));
  assert_din_high_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_cclk) |-> cfg_din);
  assert_ready_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (busy && cfg_prog_n && cfg_cclk));
  assert_done_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code == 2'd0 && !busy));
  assert_err_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'd0) |=> cfg_prog_n);
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'd0) |-> !busy);
endmodule

bind fpga_serial_loader fpga_serial_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .cfg_prog_n(cfg_prog_n),
  .cfg_cclk(cfg_cclk), .cfg_din(cfg_din), .busy(busy), .done(done), .err_code(err_code)
);

// File: tb/tb_fpga_serial_loader.sv
`timescale 1ns/1ps
module tb_fpga_serial_loader;
  localparam int CLK_P  = 10;
  localparam int PHASE  = 2;
  localparam int POLL   = 16;
  localparam int LIMIT  = 4;
  localparam int PADB   = 8;
  localparam int TMO    = POLL * LIMIT;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pad_ones = 1'b0;
  logic src_valid = 1'b0, src_last = 1'b0;
  logic [7:0] src_data = 8'h00;
  logic src_ready, cfg_prog_n, cfg_cclk, cfg_din, busy, done;
  logic cfg_init_n = 1'b1, cfg_done = 1'b0;
  logic [1:0] err_code;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [7:0] bytes_q [0:3];
  logic cap [0:255];
  int cap_n = 0, acc = 0, per_bad = 0, fall_bad = 0;
  time last_rise = 0;

  always #(CLK_P/2) clk = ~clk;

  fpga_serial_loader #(.BYTE_W(8), .PHASE_CLKS(PHASE), .POLL_CLKS(POLL),
                       .POLL_LIMIT(LIMIT), .PAD_BYTES(PADB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pad_ones(pad_ones),
    .src_valid(src_valid), .src_data(src_data), .src_last(src_last), .src_ready(src_ready),
    .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk), .cfg_din(cfg_din),
    .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
    .busy(busy), .done(done), .err_code(err_code));

  always @(posedge cfg_cclk) begin
    if (cap_n > 0 && (cap_n % 8) != 0 && ($time - last_rise) != 4*PHASE*CLK_P) per_bad++;
    last_rise = $time;
    if (cap_n < 256) cap[cap_n] = cfg_din;
    cap_n++;
  end

  always @(negedge cfg_cclk) if (cfg_din !== 1'b1) fall_bad++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      src_valid = 1'b1; src_data = bytes_q[i]; src_last = (i == n-1);
      forever begin
        @(negedge clk);
        if (src_ready) break;
      end
      acc++;
      @(negedge clk);
      src_valid = 1'b0;
    end
  endtask

  task automatic wait_lvl(input int which, input logic lvl, output int cyc);
    cyc = 0;
    while (cyc < 2000) begin
      if (which == 0 && cfg_prog_n == lvl) break;
      if (which == 1 && busy == lvl) break;
      if (which == 2 && err_code != 2'd0) break;
      @(negedge clk); cyc++;
    end
  endtask

  // mode: 0 success, 1 no init low, 2 no init high, 3 no done
  task automatic run_case(input int n, input bit pad, input int mode);
    int cyc, exp_bits, mism;
    cfg_init_n = 1'b1; cfg_done = 1'b0; acc = 0; per_bad = 0; fall_bad = 0;
    pad_ones = pad;
    @(negedge clk);
    cap_n = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_lvl(0, 1'b0, cyc);
    check(!cfg_prog_n && cfg_cclk && cfg_din && busy, "R2 program low, clock/data high", {cfg_prog_n, cfg_cclk, cfg_din, busy}, 4'b0111);
    if (mode == 1) begin
      wait_lvl(2, 1'b0, cyc);
      check(err_code == 2'd1, "R3 error code", err_code, 1);
      check(cyc >= TMO-2 && cyc <= TMO+1, "R3 timeout cycles", cyc, TMO-1);
      @(negedge clk);
      check(cfg_prog_n && !busy, "R3 program released", cfg_prog_n, 1);
      return;
    end
    repeat (5) @(negedge clk);
    cfg_init_n = 1'b0;
    wait_lvl(0, 1'b1, cyc);
    if (mode == 2) begin
      wait_lvl(2, 1'b0, cyc);
      check(err_code == 2'd2, "R4 error code", err_code, 2);
      check(cyc >= TMO-2 && cyc <= TMO+1, "R4 timeout cycles", cyc, TMO-1);
      return;
    end
    repeat (6) @(negedge clk);
    cfg_init_n = 1'b1;
    fork feed(n); join_none
    exp_bits = 8*n + (pad ? 8*PADB : 0);
    cyc = 0;
    while (cap_n < exp_bits && cyc < 20000) begin @(negedge clk); cyc++; end
    repeat (4*PHASE + 4) @(negedge clk);
    check(cap_n == exp_bits, "R8 bit count", cap_n, exp_bits);
    check(acc == n, "R11 bytes taken", acc, n);
    mism = 0;
    for (int i = 0; i < exp_bits && i < 256; i++) begin
      logic e;
      e = (i < 8*n) ? bytes_q[i/8][7 - (i%8)] : 1'b1;
      if (cap[i] !== e) mism++;
    end
    check(mism == 0, "R7 bit order", mism, 0);
    check(per_bad == 0, "R5 bit period", per_bad, 0);
    check(fall_bad == 0, "R6 data high at falling clock", fall_bad, 0);
    if (mode == 3) begin
      wait_lvl(2, 1'b0, cyc);
      check(err_code == 2'd3, "R9 error code", err_code, 3);
      check(!busy && !done, "R9 idle without done", {busy, done}, 0);
      return;
    end
    cfg_done = 1'b1;
    wait_lvl(1, 1'b0, cyc);
    repeat (3) @(negedge clk);
    check(done && err_code == 2'd0 && !busy, "R10 success result", {done, err_code, busy}, 4'b1000);
  endtask

  initial begin
    #(CLK_P*150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cfg_prog_n && cfg_cclk && cfg_din && !busy && !done && err_code == 0,
          "R1 reset state", {cfg_prog_n, cfg_cclk, cfg_din, busy, done, err_code}, 7'b1110000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int n = 1; n <= 4; n++) begin
      for (int p = 0; p < 2; p++) begin
        for (int k = 0; k < 4; k++) begin
          case ((n + k + p) % 6)
            0: bytes_q[k] = 8'h00;
            1: bytes_q[k] = 8'hFF;
            2: bytes_q[k] = 8'h80;
            3: bytes_q[k] = 8'h01;
            default: bytes_q[k] = 8'((n*37 + k*91 + p*13 + 5) & 255);
          endcase
        end
        run_case(n, p[0], 0);
      end
    end
    bytes_q[0] = 8'hA5;
    run_case(1, 1'b0, 1);
    run_case(1, 1'b0, 2);
    bytes_q[0] = 8'h3C; bytes_q[1] = 8'h00;
    run_case(2, 1'b1, 3);
    run_case(1, 1'b0, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule